// File: doc/BRIEF.md
# E1 Timeslot Tap

This block sits on the serial bit path of a 2.048 Mbit/s E1 link, after the frame synchronizer. The synchronizer supplies a bit-enable, the position of the current bit within the 256-bit frame, and a flag that says the frame is aligned. From the upper bits of the position, the block works out which of the 32 eight-bit timeslots is passing. While the frame is aligned it issues one strobe at the start of each slot.

One slot is chosen, either slot 16 (the common-channel signalling slot, used when no custom choice is made) or a slot number given on a port. In extract mode the eight bits of the chosen slot are collected into a receive byte, which is flagged by a one-cycle valid pulse. In place mode with write enable set, the chosen slot is overwritten in the outgoing stream with a supplied byte. Every other bit is copied from input to output, one bit-enable later, so the block can sit transparently between two links. Both functions are driven by one slot-number compare.

Top module: `e1_slot_tap`

## Requirements
- R1: After a synchronous active-low reset, `tx_bit`, `rx_byte`, `rx_valid` and `slot_stb` are all zero.
- R2: The slot index is `bit_cnt[7:3]` and the bit within the slot is `bit_cnt[2:0]`. In the cycle after a `bit_en` cycle with `frame_lock` high and `bit_cnt[2:0]` equal to 0, `slot_stb` has exactly bit `bit_cnt[7:3]` set. At all other times `slot_stb` is zero, and it is always zero while `frame_lock` is low.
- R3: In extract mode (`place_mode` = 0), the eight bits of the chosen slot are stored in `rx_byte` most significant bit first: bit 0 of the slot goes to `rx_byte[7]`. `rx_byte` changes only when `rx_valid` is high.
- R4: `rx_valid` is high for exactly one cycle, the cycle after the `bit_en` of the slot's last bit (`bit_cnt[2:0]` = 7), and `rx_byte` already holds the new byte in that cycle.
- R5: In place mode (`place_mode` = 1) with `wr_en` high at the slot's first bit, `tx_bit` carries `tx_byte` most significant bit first in place of the chosen slot's input bits. With `wr_en` low, the slot passes through unchanged.
- R6: Every bit that is not replaced appears on `tx_bit` one cycle after its `bit_en` cycle, and `tx_bit` holds its value between `bit_en` cycles.
- R7: With `sel_custom` = 0 the chosen slot is slot 16. With `sel_custom` = 1 it is `slot_sel`, and any slot from 0 to 31 may be chosen.
- R8: `tx_byte`, `place_mode` and `wr_en` are sampled at the chosen slot's first bit. A change to `tx_byte` later in the slot does not alter the bits sent.
- R9: If `frame_lock` falls inside the chosen slot, the partial capture is dropped: there is no `rx_valid` and `rx_byte` keeps its old value. Replacement stops, and from the first unlocked bit onward `tx_bit` follows `rx_bit`.
- R10: In place mode no capture takes place and `rx_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | One-cycle strobe, one per line bit |
| rx_bit | input | 1 | Incoming serial bit, valid with `bit_en` |
| bit_cnt | input | 8 | Position of `rx_bit` within the frame, 0 to 255 |
| frame_lock | input | 1 | High while the synchronizer holds frame alignment |
| sel_custom | input | 1 | 0 selects slot 16, 1 selects `slot_sel` |
| slot_sel | input | 5 | Custom slot number |
| place_mode | input | 1 | 0 extract, 1 place |
| wr_en | input | 1 | Enables replacement in place mode |
| tx_byte | input | 8 | Byte written into the chosen slot |
| tx_bit | output | 1 | Outgoing serial bit |
| rx_byte | output | 8 | Last byte captured from the chosen slot |
| rx_valid | output | 1 | One-cycle pulse when `rx_byte` is updated |
| slot_stb | output | 32 | One-hot start-of-slot strobes |

## Verification
Some properties are checked by assertions on every cycle. These are: the strobes are one-hot, and they appear only after a locked `bit_en`. The valid flag is a single-cycle pulse that follows a locked cycle, and the receive byte does not change without it. Whenever lock is low, the output copies the input, and the output is held steady between bit enables. Other behaviour can only be shown by the bench's frame-long scenarios, because it depends on the content of whole slots. This includes the value of the captured byte, the exact bits written into a placed slot, the slot chosen by default and by a custom choice, the effect of a transmit byte that changes in the middle of a slot, and recovery after a capture that was dropped.

// File: rtl/e1_tap_pkg.sv
// Package: shared constants and the mode encoding for the E1 timeslot tap.
// Assumes a 32-slot, 8-bit-per-slot frame unless a module overrides its parameters.
package e1_tap_pkg;
    localparam int TAP_SLOTS     = 32;
    localparam int TAP_BYTE_W    = 8;
    localparam int TAP_DFLT_SLOT = 16;

    typedef enum logic {
        MODE_EXTRACT = 1'b0,
        MODE_PLACE   = 1'b1
    } tap_mode_e;
endpackage

// File: rtl/e1_slot_timer.sv
// Module: e1_slot_timer
// Splits the frame bit counter into a slot index and a bit phase. While the frame
// is locked, it drives one registered start-of-slot strobe for each slot.
// Assumes bit_cnt holds the position of the bit that arrives with bit_en.
module e1_slot_timer
    import e1_tap_pkg::*;
#(
    parameter int SLOTS  = TAP_SLOTS,
    parameter int BYTE_W = TAP_BYTE_W,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int PH_W   = $clog2(BYTE_W),
    localparam int CNT_W  = SLOT_W + PH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              frame_lock,
    input  logic [CNT_W-1:0]  bit_cnt,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              first_bit,
    output logic              last_bit,
    output logic [SLOTS-1:0]  slot_stb
);
    logic [SLOTS-1:0] stb_d;

    // Decode the counter into slot index and position inside the slot.
    always_comb begin
        slot_idx  = bit_cnt[CNT_W-1:PH_W];
        first_bit = (bit_cnt[PH_W-1:0] == '0);
        last_bit  = (bit_cnt[PH_W-1:0] == PH_W'(BYTE_W - 1));
    end

    // One comparator per slot; a strobe fires only on a locked first bit.
    for (genvar g = 0; g < SLOTS; g++) begin : g_stb
        assign stb_d[g] = bit_en && frame_lock && first_bit && (slot_idx == SLOT_W'(g));
    end

    // Register the strobes so that they align with the serial output.
    always_ff @(posedge clk) begin
        if (!rst_n) slot_stb <= '0;
        else        slot_stb <= stb_d;
    end

    AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_stb)); // R2
    AST_STB_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && slot_stb != '0) |-> ($past(bit_en) && $past(frame_lock))); // R2
endmodule

// File: rtl/e1_slot_capture.sv
// Module: e1_slot_capture
// Shifts the bits of the chosen slot in MSB first and publishes the byte with a
// one-cycle valid pulse. The start decision is made outside this module. Loss of
// lock drops a capture that is in progress.
module e1_slot_capture
    import e1_tap_pkg::*;
#(
    parameter int BYTE_W = TAP_BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              frame_lock,
    input  logic              rx_bit,
    input  logic              cap_start,
    input  logic              last_bit,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid
);
    logic              cap_act;
    logic [BYTE_W-2:0] sh_q;

    // Collect the slot bits; a valid pulse and the new byte appear together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_act  <= 1'b0;
            sh_q     <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (!frame_lock) begin
                cap_act <= 1'b0;
            end else if (cap_start) begin
                cap_act <= 1'b1;
                sh_q    <= (BYTE_W-1)'(rx_bit);
            end else if (bit_en && cap_act) begin
                if (last_bit) begin
                    rx_byte  <= {sh_q, rx_bit};
                    rx_valid <= 1'b1;
                    cap_act  <= 1'b0;
                end else begin
                    sh_q <= {sh_q[BYTE_W-3:0], rx_bit};
                end
            end
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R4
    AST_VALID_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && rx_valid) |-> $past(frame_lock)); // R9
    AST_BYTE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !rx_valid) |-> $stable(rx_byte)); // R3
endmodule

// File: rtl/e1_slot_insert.sv
// Module: e1_slot_insert
// Drives the outgoing serial bit. Bits are copied through by default. When a
// placement starts, the latched byte is sent MSB first for one slot. Replacement
// ends as soon as lock drops.
module e1_slot_insert
    import e1_tap_pkg::*;
#(
    parameter int BYTE_W = TAP_BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              frame_lock,
    input  logic              rx_bit,
    input  logic              ins_start,
    input  logic              last_bit,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              tx_bit
);
    logic              ins_act;
    logic [BYTE_W-2:0] ins_sh;

    // Choose, for each line bit, between the input bit and the placed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_bit  <= 1'b0;
            ins_act <= 1'b0;
            ins_sh  <= '0;
        end else begin
            if (!frame_lock) ins_act <= 1'b0;
            if (bit_en) begin
                if (ins_start) begin
                    tx_bit  <= tx_byte[BYTE_W-1];
                    ins_sh  <= tx_byte[BYTE_W-2:0];
                    ins_act <= 1'b1;
                end else if (ins_act && frame_lock) begin
                    tx_bit <= ins_sh[BYTE_W-2];
                    ins_sh <= {ins_sh[BYTE_W-3:0], 1'b0};
                    if (last_bit) ins_act <= 1'b0;
                end else begin
                    tx_bit <= rx_bit;
                end
            end
        end
    end

    AST_TX_PASS_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bit_en) && !$past(frame_lock)) |-> (tx_bit == $past(rx_bit))); // R9
    AST_TX_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(bit_en)) |-> $stable(tx_bit)); // R6
endmodule

// File: rtl/e1_slot_tap.sv
// Module: e1_slot_tap (top)
// The E1 timeslot tap. It picks one slot (the default or a custom number) and
// compares it once against the current slot index. That single compare starts
// either an MSB-first capture or an in-line replacement of the slot. All other
// bits pass through with a latency of one bit-enable.
// Assumes the synchronizer supplies bit_en, bit_cnt and frame_lock.
module e1_slot_tap
    import e1_tap_pkg::*;
#(
    parameter int SLOTS     = TAP_SLOTS,
    parameter int BYTE_W    = TAP_BYTE_W,
    parameter int DFLT_SLOT = TAP_DFLT_SLOT,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int PH_W   = $clog2(BYTE_W),
    localparam int CNT_W  = SLOT_W + PH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              rx_bit,
    input  logic [CNT_W-1:0]  bit_cnt,
    input  logic              frame_lock,
    input  logic              sel_custom,
    input  logic [SLOT_W-1:0] slot_sel,
    input  logic              place_mode,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              tx_bit,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic [SLOTS-1:0]  slot_stb
);
    logic [SLOT_W-1:0] slot_idx;
    logic              first_bit;
    logic              last_bit;
    logic [SLOT_W-1:0] active_sel;
    logic              slot_hit;
    logic              start_any;
    logic              cap_start;
    logic              ins_start;
    tap_mode_e         mode;

    // Resolve the chosen slot and the single shared compare that starts a slot action.
    always_comb begin
        mode       = tap_mode_e'(place_mode);
        active_sel = sel_custom ? slot_sel : SLOT_W'(DFLT_SLOT);
        slot_hit   = (slot_idx == active_sel);
        start_any  = bit_en && frame_lock && first_bit && slot_hit;
        cap_start  = start_any && (mode == MODE_EXTRACT);
        ins_start  = start_any && (mode == MODE_PLACE) && wr_en;
    end

    e1_slot_timer #(.SLOTS(SLOTS), .BYTE_W(BYTE_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_lock(frame_lock),
        .bit_cnt(bit_cnt), .slot_idx(slot_idx), .first_bit(first_bit),
        .last_bit(last_bit), .slot_stb(slot_stb)
    );

    e1_slot_capture #(.BYTE_W(BYTE_W)) capture_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_lock(frame_lock),
        .rx_bit(rx_bit), .cap_start(cap_start), .last_bit(last_bit),
        .rx_byte(rx_byte), .rx_valid(rx_valid)
    );

    e1_slot_insert #(.BYTE_W(BYTE_W)) insert_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_lock(frame_lock),
        .rx_bit(rx_bit), .ins_start(ins_start), .last_bit(last_bit),
        .tx_byte(tx_byte), .tx_bit(tx_bit)
    );

    AST_NO_VALID_IN_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bit_en) && $past(place_mode) && $past(last_bit)) |-> !rx_valid); // R10
endmodule

// File: tb/e1_slot_tap_tb.sv
// Bench for e1_slot_tap. A table of slot configurations is run one frame each,
// followed by directed tests for reset, loss of lock and mid-slot byte changes.
module e1_slot_tap_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        rx_bit = 1'b0;
    logic [7:0]  bit_cnt = '0;
    logic        frame_lock = 1'b0;
    logic        sel_custom = 1'b0;
    logic [4:0]  slot_sel = '0;
    logic        place_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  tx_byte = '0;
    logic        tx_bit;
    logic [7:0]  rx_byte;
    logic        rx_valid;
    logic [31:0] slot_stb;

    int checks = 0;
    int fails = 0;
    int frame_no = 0;
    logic [7:0]  exp_byte = '0;
    logic        obs_tx, obs_v;
    logic [31:0] obs_stb;

    always #2 clk = ~clk;

    e1_slot_tap dut_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
        .bit_cnt(bit_cnt), .frame_lock(frame_lock), .sel_custom(sel_custom),
        .slot_sel(slot_sel), .place_mode(place_mode), .wr_en(wr_en),
        .tx_byte(tx_byte), .tx_bit(tx_bit), .rx_byte(rx_byte),
        .rx_valid(rx_valid), .slot_stb(slot_stb)
    );

    // {custom, sel[4:0], place, wr, txb[7:0]}
    localparam logic [15:0] VEC [8] = '{
        {1'b0, 5'd3,  1'b0, 1'b0, 8'h00},
        {1'b1, 5'd5,  1'b0, 1'b0, 8'h00},
        {1'b1, 5'd31, 1'b0, 1'b0, 8'h00},
        {1'b1, 5'd0,  1'b0, 1'b0, 8'h00},
        {1'b1, 5'd9,  1'b1, 1'b1, 8'hA5},
        {1'b1, 5'd31, 1'b1, 1'b1, 8'h3C},
        {1'b1, 5'd12, 1'b1, 1'b0, 8'hFF},
        {1'b0, 5'd2,  1'b1, 1'b1, 8'hC3}
    };

    function automatic logic [7:0] pat(int f, int s);
        return 8'((s * 37 + f * 11 + 90) ^ (s * 8));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input logic b, input logic [7:0] c, input logic l);
        @(negedge clk);
        bit_en = 1'b1; rx_bit = b; bit_cnt = c; frame_lock = l;
        @(negedge clk);
        obs_tx = tx_bit; obs_v = rx_valid; obs_stb = slot_stb;
        bit_en = 1'b0;
    endtask

    task automatic run_frame(input bit custom, input logic [4:0] sel, input bit place,
                             input bit wr, input logic [7:0] txb, input int drop_at,
                             input bit mid_change, input bit lock_all, input string tag);
        int target, m_stb, m_tx, m_v;
        target = custom ? int'(sel) : 16;
        m_stb = 0; m_tx = 0; m_v = 0;
        sel_custom = custom; slot_sel = sel; place_mode = place; wr_en = wr; tx_byte = txb;
        for (int p = 0; p < 256; p++) begin
            int s, k;
            logic lkp, b, exp_tx, exp_v;
            logic [31:0] exp_stb;
            s = p / 8; k = p % 8;
            lkp = lock_all && (drop_at < 0 || p < drop_at);
            b = pat(frame_no, s)[7-k];
            if (mid_change && s == target && k == 1) tx_byte = ~txb;
            tick(b, 8'(p), lkp);
            exp_tx  = (place && wr && s == target && lkp) ? txb[7-k] : b;
            exp_stb = (lkp && k == 0) ? (32'd1 << s) : 32'd0;
            exp_v   = !place && s == target && k == 7 && lkp;
            if (obs_tx != exp_tx) m_tx++;
            if (obs_stb != exp_stb) m_stb++;
            if (obs_v != exp_v) m_v++;
            if (exp_v) exp_byte = pat(frame_no, s);
        end
        chk(m_stb == 0, "R2 strobe mismatches", m_stb, 0);
        chk(m_tx == 0, {tag, " tx mismatches"}, m_tx, 0);
        chk(m_v == 0, "R4 valid mismatches", m_v, 0);
        chk(rx_byte == exp_byte, "R3 rx_byte", rx_byte, exp_byte);
        frame_no++;
    endtask

    task automatic check_reset();
        chk(tx_bit == 1'b0, "R1 tx_bit", tx_bit, 0);
        chk(rx_byte == 8'h00, "R1 rx_byte", rx_byte, 0);
        chk(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
        chk(slot_stb == '0, "R1 slot_stb", slot_stb, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check_reset();                                   // R1
        rst_n = 1'b1;
        // Table walk: R7 default/custom, R3 R4 extract, R5 R6 R10 place
        for (int i = 0; i < 8; i++) begin
            run_frame(VEC[i][15], VEC[i][14:10], VEC[i][9], VEC[i][8], VEC[i][7:0],
                      -1, 1'b0, 1'b1, VEC[i][9] ? "R5" : "R6");
        end
        // R9: no lock for a whole frame, place configured -> transparent, no strobes
        run_frame(1'b1, 5'd4, 1'b1, 1'b1, 8'h81, -1, 1'b0, 1'b0, "R9");
        // R9: lock lost in the middle of an extracted slot, then recovery
        run_frame(1'b1, 5'd7, 1'b0, 1'b0, 8'h00, 60, 1'b0, 1'b1, "R9");
        run_frame(1'b1, 5'd7, 1'b0, 1'b0, 8'h00, -1, 1'b0, 1'b1, "R6");
        // R9: lock lost in the middle of a placed slot
        run_frame(1'b1, 5'd7, 1'b1, 1'b1, 8'hF0, 59, 1'b0, 1'b1, "R9");
        // R8: tx_byte changed after the slot's first bit
        run_frame(1'b1, 5'd20, 1'b1, 1'b1, 8'h6B, -1, 1'b1, 1'b1, "R8");
        // R1: reset in mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        check_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule